// File: doc/BRIEF.md
# Time Slot Table Sequencer

This block maps the time slots of a TDM serial frame onto logical channels through a small programmable table. Each table entry describes one time slot. It carries a valid flag, a wrap flag, an 8-bit bit-select mask and a 6-bit channel field. The block has two independent walkers that step through the same table, one for receive and one for transmit. Each walker has its own start pointer and its own current pointer.

Software programs the table and the two start pointers over a plain write port while the sequencer is disabled. Raising the enable input reloads both current pointers from their start pointers.

The receive path collects the eight serial bits of each slot into a byte. For an active entry it passes downstream the masked byte, a per-bit enable equal to the mask, and the channel number. The transmit path announces each active slot to the downstream transmitter with the slot's mask and channel number. Frame sync generation, channel protocol handling and buffer management sit outside this block.

Top module: `slotseq_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `rx_vld`, `tx_vld` and `rx_bit_en` are all zero.
- R2: A write with `wr_addr` MSB = 0 stores `wr_data` into the entry addressed by the low bits. Writes to an index at or above DEPTH are dropped. The entry word is laid out as follows: bit 15 is valid, bit 14 is wrap, bits 13:8 are mask[7:2], bits 7:2 are the channel field and bits 1:0 are mask[1:0]. With `wr_addr` MSB = 1, bit 0 = 0 selects the receive start pointer and bit 0 = 1 selects the transmit start pointer. The pointer value is taken from `wr_data` low bits, and values at or above DEPTH are dropped.
- R3: The first slot after enable uses the entry at the start pointer. Each later slot uses the entry after the one used before.
- R4: After a slot whose entry has the wrap bit set, or whose entry is the last physical index (DEPTH-1), the next slot uses the start pointer entry.
- R5: A slot whose first bit carries `fsync` uses the start pointer entry, whatever the current pointer holds.
- R6: Receive bits are strobed by `bit_stb`, and `slot_stb` marks the first bit of a slot. The first bit received lands in `rx_data[7]`. One cycle after the eighth bit of an active slot, `rx_vld` pulses. At that pulse `rx_data` is the byte ANDed with the mask, `rx_bit_en` equals the mask, and `rx_ch` is channel field bits 4:0.
- R7: An entry is active only when it is valid, its mask is nonzero and channel field bit 5 is zero. An inactive slot gives no `rx_vld` and no `tx_vld`, and `rx_bit_en` stays zero.
- R8: One cycle after the first bit of an active slot, `tx_vld` pulses, with `tx_mask` and `tx_ch` taken from the transmit walker's entry.
- R9: The receive and transmit walkers follow their own start pointers through the one shared table. When both start pointers are equal, both walkers use the same entries.
- R10: Table and start pointer writes are ignored while `en` is high.
- R11: While `en` is low, no `rx_vld` or `tx_vld` is produced and the bit count of a partial slot is discarded.
- R12: Bits beyond the eighth in one slot are ignored and give no further `rx_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Sequencer enable; rising edge reloads current pointers |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | IDX_W+1 | Entry index, or start pointer select when MSB set |
| wr_data | input | 16 | Entry word or start pointer value |
| fsync | input | 1 | Frame start, sampled with the first bit of a slot |
| slot_stb | input | 1 | Marks the first bit of a slot |
| bit_stb | input | 1 | Serial bit strobe |
| rx_bit | input | 1 | Serial receive bit |
| rx_vld | output | 1 | Received slot byte valid pulse |
| rx_data | output | 8 | Masked received byte |
| rx_bit_en | output | 8 | Per-bit enable of the received byte |
| rx_ch | output | 5 | Receive channel number |
| tx_vld | output | 1 | Transmit slot announcement pulse |
| tx_mask | output | 8 | Bit mask of the announced transmit slot |
| tx_ch | output | 5 | Channel number of the announced transmit slot |

## Verification
The bench builds the block with DEPTH = 6. That is not a power of two, so the index width leaves two addresses that do not exist, and the rejected-write path for entries and pointers can be reached. Six entries also let a short frame with no wrap bit fall off the last physical index within a few slots. The bench sets the two start pointers to different entries so that the walkers diverge, then sets them equal to cover the shared-table case. Random tables mix inactive entry kinds (invalid, zero mask, reserved channel bit) with random fsync placement.

// File: rtl/slotseq_pkg.sv
// Package: shared types and helpers for the time slot table sequencer.
// Assumes 8-bit slots and a 16-bit configuration word.
package slotseq_pkg;

    localparam int SLOT_BITS  = 8;
    localparam int CHAN_FLD_W = 6;
    localparam int CHAN_OUT_W = 5;
    localparam int WORD_W     = 16;

    typedef struct packed {
        logic                  valid;
        logic                  wrap;
        logic [SLOT_BITS-1:0]  mask;
        logic [CHAN_FLD_W-1:0] chan;
    } slot_entry_t;

    // Unpack a configuration word into the entry fields.
    function automatic slot_entry_t word_to_entry(input logic [WORD_W-1:0] w);
        slot_entry_t e;
        e.valid = w[15];
        e.wrap  = w[14];
        e.mask  = {w[13:8], w[1:0]};
        e.chan  = w[7:2];
        return e;
    endfunction

    // An entry is active when it is valid, selects bits and uses a legal channel.
    function automatic logic entry_active(input slot_entry_t e);
        return e.valid && (e.mask != '0) && !e.chan[CHAN_FLD_W-1];
    endfunction

endpackage

// File: rtl/slotseq_table.sv
// Module: slotseq_table
// Holds the slot entries and the per-direction start pointers.
// Accepts writes only while the sequencer is disabled.
// Gives two combinational read ports, one per walker.
// Assumes: DEPTH >= 2; read indices are always below DEPTH.
module slotseq_table
    import slotseq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int NPORT = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en,
    input  logic                         wr_en,
    input  logic [IDX_W:0]               wr_addr,
    input  logic [WORD_W-1:0]            wr_data,
    input  logic [NPORT-1:0][IDX_W-1:0]  rd_idx,
    output slot_entry_t [NPORT-1:0]      rd_ent,
    output logic [NPORT-1:0][IDX_W-1:0]  start_ptr
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    slot_entry_t                       tab_q [DEPTH];
    logic [NPORT-1:0][IDX_W-1:0]       start_q;

    logic                              wr_ok;
    logic                              wr_is_ptr;
    logic [IDX_W-1:0]                  wr_idx;
    logic [IDX_W-1:0]                  ptr_val;

    // Decode the write request into entry or pointer target.
    always_comb begin
        wr_ok     = wr_en && !en;
        wr_is_ptr = wr_addr[IDX_W];
        wr_idx    = wr_addr[IDX_W-1:0];
        ptr_val   = wr_data[IDX_W-1:0];
    end

    // Entry storage: one register set per table entry.
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_entry
            // Store the entry word when its index is addressed.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tab_q[i] <= '0;
                end else if (wr_ok && !wr_is_ptr && (wr_idx == IDX_W'(i))) begin
                    tab_q[i] <= word_to_entry(wr_data);
                end
            end
        end
    endgenerate

    // Start pointers: selected by address bit 0, legal values only.
    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_start
            // Load this direction's start pointer.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    start_q[p] <= '0;
                end else if (wr_ok && wr_is_ptr && (wr_addr[0] == p[0])
                             && (ptr_val <= LAST_IDX)) begin
                    start_q[p] <= ptr_val;
                end
            end
        end
    endgenerate

    assign start_ptr = start_q;

    // Read ports: guarded against indices past the last entry.
    generate
        for (genvar r = 0; r < NPORT; r++) begin : g_read
            // Select the entry for this walker.
            always_comb begin
                if (rd_idx[r] <= LAST_IDX) begin
                    rd_ent[r] = tab_q[rd_idx[r]];
                end else begin
                    rd_ent[r] = '0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/slotseq_walker.sv
// Module: slotseq_walker
// Steps one current pointer through the table, one entry per slot.
// Latches the entry fields used for the slot in progress.
// Assumes: slot_go is a single-cycle strobe on the first bit of a slot,
// already qualified with enable.
module slotseq_walker
    import slotseq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   slot_go,
    input  logic                   fsync,
    input  logic [IDX_W-1:0]       start_ptr,
    input  slot_entry_t            rd_ent,
    output logic [IDX_W-1:0]       rd_idx,
    output logic [SLOT_BITS-1:0]   cur_mask,
    output logic [CHAN_OUT_W-1:0]  cur_ch,
    output logic                   cur_act
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] nxt_idx;

    // Entry used by the arriving slot: frame sync restarts at the start pointer.
    assign rd_idx = fsync ? start_ptr : ptr_q;

    // Successor: wrap flag or the last physical index return to the start.
    always_comb begin
        if (rd_ent.wrap || (rd_idx == LAST_IDX)) begin
            nxt_idx = start_ptr;
        end else begin
            nxt_idx = rd_idx + 1'b1;
        end
    end

    // Pointer and latched-entry state for the slot in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            cur_mask <= '0;
            cur_ch   <= '0;
            cur_act  <= 1'b0;
        end else if (!en) begin
            ptr_q   <= start_ptr;
            cur_act <= 1'b0;
        end else if (slot_go) begin
            ptr_q    <= nxt_idx;
            cur_mask <= rd_ent.mask;
            cur_ch   <= rd_ent.chan[CHAN_OUT_W-1:0];
            cur_act  <= entry_active(rd_ent);
        end
    end

endmodule

// File: rtl/slotseq_rx_asm.sv
// Module: slotseq_rx_asm
// Shifts the serial bits of one slot into a byte, MSB first.
// Emits the masked byte, its bit enables and the channel after the last bit.
// Assumes: the walker latches the slot entry on the slot's first bit.
module slotseq_rx_asm
    import slotseq_pkg::*;
#(
    parameter int BITS = SLOT_BITS,
    parameter int CNT_W = $clog2(BITS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   bit_stb,
    input  logic                   slot_stb,
    input  logic                   rx_bit,
    input  logic [BITS-1:0]        cur_mask,
    input  logic [CHAN_OUT_W-1:0]  cur_ch,
    input  logic                   cur_act,
    output logic                   rx_vld,
    output logic [BITS-1:0]        rx_data,
    output logic [BITS-1:0]        rx_bit_en,
    output logic [CHAN_OUT_W-1:0]  rx_ch
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BITS);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BITS - 1);

    logic [BITS-1:0]  sh_q;
    logic [CNT_W-1:0] cnt_q;
    logic [BITS-1:0]  byte_full;
    logic             take_bit;
    logic             last_bit;

    // Qualify the arriving bit and detect the final bit of the slot.
    always_comb begin
        byte_full = {sh_q[BITS-2:0], rx_bit};
        take_bit  = bit_stb && !slot_stb && (cnt_q != '0) && (cnt_q < FULL_CNT);
        last_bit  = take_bit && (cnt_q == LAST_CNT);
    end

    // Bit collection and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q      <= '0;
            cnt_q     <= '0;
            rx_vld    <= 1'b0;
            rx_data   <= '0;
            rx_bit_en <= '0;
            rx_ch     <= '0;
        end else if (!en) begin
            cnt_q     <= '0;
            rx_vld    <= 1'b0;
            rx_bit_en <= '0;
        end else begin
            rx_vld    <= 1'b0;
            rx_bit_en <= '0;
            if (bit_stb && slot_stb) begin
                sh_q  <= {{(BITS-1){1'b0}}, rx_bit};
                cnt_q <= CNT_W'(1);
            end else if (take_bit) begin
                sh_q  <= byte_full;
                cnt_q <= cnt_q + 1'b1;
            end
            if (last_bit && cur_act) begin
                rx_vld    <= 1'b1;
                rx_data   <= byte_full & cur_mask;
                rx_bit_en <= cur_mask;
                rx_ch     <= cur_ch;
            end
        end
    end

endmodule

// File: rtl/slotseq_top.sv
// Module: slotseq_top
// Time slot table sequencer: shared slot table, receive and transmit
// walkers, and receive byte assembly.
// Assumes: fsync and slot_stb are only meaningful together with bit_stb.
module slotseq_top
    import slotseq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   wr_en,
    input  logic [IDX_W:0]         wr_addr,
    input  logic [15:0]            wr_data,
    input  logic                   fsync,
    input  logic                   slot_stb,
    input  logic                   bit_stb,
    input  logic                   rx_bit,
    output logic                   rx_vld,
    output logic [7:0]             rx_data,
    output logic [7:0]             rx_bit_en,
    output logic [4:0]             rx_ch,
    output logic                   tx_vld,
    output logic [7:0]             tx_mask,
    output logic [4:0]             tx_ch
);

    localparam int NDIR   = 2;
    localparam int DIR_RX = 0;
    localparam int DIR_TX = 1;

    logic                                slot_go;
    logic                                tx_go_q;
    logic [NDIR-1:0][IDX_W-1:0]          rd_idx;
    slot_entry_t [NDIR-1:0]              rd_ent;
    logic [NDIR-1:0][IDX_W-1:0]          start_ptr;
    logic [NDIR-1:0][SLOT_BITS-1:0]      cur_mask;
    logic [NDIR-1:0][CHAN_OUT_W-1:0]     cur_ch;
    logic [NDIR-1:0]                     cur_act;

    // A slot begins on a qualified first-bit strobe.
    assign slot_go = en && slot_stb && bit_stb;

    slotseq_table #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W),
        .NPORT (NDIR)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .rd_ent    (rd_ent),
        .start_ptr (start_ptr)
    );

    generate
        for (genvar d = 0; d < NDIR; d++) begin : g_dir
            slotseq_walker #(
                .DEPTH (DEPTH),
                .IDX_W (IDX_W)
            ) u_walker (
                .clk       (clk),
                .rst_n     (rst_n),
                .en        (en),
                .slot_go   (slot_go),
                .fsync     (fsync),
                .start_ptr (start_ptr[d]),
                .rd_ent    (rd_ent[d]),
                .rd_idx    (rd_idx[d]),
                .cur_mask  (cur_mask[d]),
                .cur_ch    (cur_ch[d]),
                .cur_act   (cur_act[d])
            );
        end
    endgenerate

    slotseq_rx_asm u_rx_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .bit_stb   (bit_stb),
        .slot_stb  (slot_stb),
        .rx_bit    (rx_bit),
        .cur_mask  (cur_mask[DIR_RX]),
        .cur_ch    (cur_ch[DIR_RX]),
        .cur_act   (cur_act[DIR_RX]),
        .rx_vld    (rx_vld),
        .rx_data   (rx_data),
        .rx_bit_en (rx_bit_en),
        .rx_ch     (rx_ch)
    );

    // Delay the slot start by one cycle to line up with the latched entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_go_q <= 1'b0;
        end else begin
            tx_go_q <= slot_go;
        end
    end

    assign tx_vld  = tx_go_q && cur_act[DIR_TX];
    assign tx_mask = cur_mask[DIR_TX];
    assign tx_ch   = cur_ch[DIR_TX];

endmodule

// File: rtl/slotseq_checker.sv
// Module: slotseq_checker
// Port-level properties of the sequencer, bound onto slotseq_top.
module slotseq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       slot_stb,
    input logic       bit_stb,
    input logic       rx_vld,
    input logic [7:0] rx_data,
    input logic [7:0] rx_bit_en,
    input logic       tx_vld,
    input logic [7:0] tx_mask
);

    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        !$past(rst_n) |-> (!rx_vld && !tx_vld && (rx_bit_en == '0)));

    assert_rx_follows_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_vld |-> $past(bit_stb && en && !slot_stb));

    assert_rx_data_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_vld |-> ((rx_data & ~rx_bit_en) == '0));

    assert_rx_enable_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_vld |-> (rx_bit_en != '0));

    assert_idle_enables_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_vld |-> (rx_bit_en == '0));

    assert_tx_follows_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_vld |-> $past(slot_stb && bit_stb && en));

    assert_tx_mask_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_vld |-> (tx_mask != '0));

    assert_disabled_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (!rx_vld && !tx_vld));

endmodule

bind slotseq_top slotseq_checker u_slotseq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .slot_stb  (slot_stb),
    .bit_stb   (bit_stb),
    .rx_vld    (rx_vld),
    .rx_data   (rx_data),
    .rx_bit_en (rx_bit_en),
    .tx_vld    (tx_vld),
    .tx_mask   (tx_mask)
);

// File: tb/slotseq_top_bench.sv
module slotseq_top_bench;

    localparam int CLK_P = 10;
    localparam int DEPTH = 6;
    localparam int IDX_W = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             wr_en = 1'b0;
    logic [IDX_W:0]   wr_addr = '0;
    logic [15:0]      wr_data = '0;
    logic             fsync = 1'b0;
    logic             slot_stb = 1'b0;
    logic             bit_stb = 1'b0;
    logic             rx_bit = 1'b0;
    logic             rx_vld;
    logic [7:0]       rx_data;
    logic [7:0]       rx_bit_en;
    logic [4:0]       rx_ch;
    logic             tx_vld;
    logic [7:0]       tx_mask;
    logic [4:0]       tx_ch;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [15:0] m_tab [DEPTH];
    int          m_start [2];
    int          m_ptr [2];
    bit          m_en = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    slotseq_top #(.DEPTH(DEPTH)) u_slotseq_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .fsync     (fsync),
        .slot_stb  (slot_stb),
        .bit_stb   (bit_stb),
        .rx_bit    (rx_bit),
        .rx_vld    (rx_vld),
        .rx_data   (rx_data),
        .rx_bit_en (rx_bit_en),
        .rx_ch     (rx_ch),
        .tx_vld    (tx_vld),
        .tx_mask   (tx_mask),
        .tx_ch     (tx_ch)
    );

    function automatic logic [15:0] mk(bit v, bit w, logic [7:0] m, logic [5:0] ch);
        return {v, w, m[7:2], ch, m[1:0]};
    endfunction

    function automatic logic [7:0] f_mask(logic [15:0] w);
        return {w[13:8], w[1:0]};
    endfunction

    function automatic logic [4:0] f_ch(logic [15:0] w);
        return w[6:2];
    endfunction

    function automatic bit f_act(logic [15:0] w);
        return w[15] && (f_mask(w) != 8'h00) && !w[7];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // Configuration write; the model follows only legal, disabled writes (R2, R10).
    task automatic wr(logic [IDX_W:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        if (!m_en) begin
            if (!a[IDX_W]) begin
                if (int'(a[IDX_W-1:0]) < DEPTH) m_tab[a[IDX_W-1:0]] = d;
            end else if (int'(d[IDX_W-1:0]) < DEPTH) begin
                m_start[a[0]] = int'(d[IDX_W-1:0]);
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_en(bit v);
        @(negedge clk);
        en = v;
        m_en = v;
        if (v) begin
            m_ptr[0] = m_start[0];
            m_ptr[1] = m_start[1];
        end
    endtask

    // Send one slot of 8 bits plus extra bits, checking tx and rx outputs.
    task automatic send_slot(bit fs, logic [7:0] byt, int extra, string req);
        logic [15:0] w [2];
        int idx;
        bit a [2];
        for (int d = 0; d < 2; d++) begin
            idx = fs ? m_start[d] : m_ptr[d];
            w[d] = m_tab[idx];
            a[d] = m_en && f_act(w[d]);
            if (m_en) begin
                if (w[d][14] || idx == DEPTH-1) m_ptr[d] = m_start[d];
                else m_ptr[d] = idx + 1;
            end
        end
        for (int b = 0; b < 8 + extra; b++) begin
            @(negedge clk);
            if (b == 1) begin
                check({req, " R8 tx_vld"}, 32'(tx_vld), 32'(a[1]));
                if (a[1]) begin
                    check({req, " R8 tx_mask"}, 32'(tx_mask), 32'(f_mask(w[1])));
                    check({req, " R8 tx_ch"}, 32'(tx_ch), 32'(f_ch(w[1])));
                end
            end
            if (b == 8) check({req, " R6 rx_vld"}, 32'(rx_vld), 32'(a[0]));
            bit_stb = 1'b1;
            slot_stb = (b == 0);
            fsync = (b == 0) && fs;
            rx_bit = (b < 8) ? byt[7-b] : 1'($urandom);
        end
        @(negedge clk);
        if (extra == 0) begin
            check({req, " R6 rx_vld"}, 32'(rx_vld), 32'(a[0]));
            if (a[0]) begin
                check({req, " R6 rx_data"}, 32'(rx_data), 32'(byt & f_mask(w[0])));
                check({req, " R6 rx_bit_en"}, 32'(rx_bit_en), 32'(f_mask(w[0])));
                check({req, " R6 rx_ch"}, 32'(rx_ch), 32'(f_ch(w[0])));
            end else begin
                check({req, " R7 rx_bit_en idle"}, 32'(rx_bit_en), 32'h0);
            end
        end else begin
            check({req, " R12 no extra rx_vld"}, 32'(rx_vld), 32'h0);
        end
        bit_stb = 1'b0; slot_stb = 1'b0; fsync = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < DEPTH; i++) m_tab[i] = '0;
        m_start[0] = 0; m_start[1] = 0;
        m_ptr[0] = 0; m_ptr[1] = 0;
        repeat (3) @(negedge clk);
        check("R1 rx_vld in reset", 32'(rx_vld), 0);
        check("R1 tx_vld in reset", 32'(tx_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rx_bit_en after reset", 32'(rx_bit_en), 0);
        check("R1 tx_vld after reset", 32'(tx_vld), 0);

        // Directed table: active, zero mask, invalid, reserved channel, wrap (R2, R7).
        wr(4'b0000, mk(1, 0, 8'hFF, 6'd3));
        wr(4'b0001, mk(1, 0, 8'h0F, 6'd7));
        wr(4'b0010, mk(1, 0, 8'h00, 6'd9));
        wr(4'b0011, mk(0, 0, 8'hFF, 6'd4));
        wr(4'b0100, mk(1, 0, 8'hFF, 6'd33));
        wr(4'b0101, mk(1, 1, 8'hF0, 6'd31));
        wr(4'b0110, mk(1, 1, 8'hFF, 6'd1));   // index 6 does not exist (R2)
        wr(4'b1000, 16'd0);
        wr(4'b1001, 16'd2);
        wr(4'b1000, 16'd7);                   // illegal start value dropped (R2)
        set_en(1);
        // R3, R4, R9: walk past the wrap entry on both walkers.
        for (int s = 0; s < 9; s++) send_slot(0, 8'(8'hA5 + s), 0, "R3 R4 R9 walk");
        // R5: frame sync mid-table restarts at the start entries.
        send_slot(1, 8'h3C, 0, "R5 fsync");
        send_slot(0, 8'hC3, 0, "R5 after fsync");
        // R10: writes while enabled are ignored.
        wr(4'b0000, mk(1, 0, 8'h01, 6'd12));
        wr(4'b1000, 16'd5);
        send_slot(1, 8'hFF, 0, "R10 ignored write");
        // R12: extra bits in a slot.
        send_slot(0, 8'h81, 3, "R12 extra bits");
        send_slot(0, 8'h7E, 0, "R12 next slot");
        // R11: disabled, nothing comes out; partial slot discarded.
        set_en(0);
        send_slot(0, 8'h55, 0, "R11 disabled");
        // R4 last physical index without wrap, R9 shared start.
        wr(4'b0101, mk(1, 0, 8'hF0, 6'd31));
        wr(4'b1000, 16'd4);
        wr(4'b1001, 16'd4);
        set_en(1);
        for (int s = 0; s < 5; s++) send_slot(0, 8'(8'h11 * (s + 1)), 0, "R4 R9 last index");

        // Random phase.
        for (int f = 0; f < 60; f++) begin
            set_en(0);
            for (int i = 0; i < DEPTH; i++) begin
                logic [5:0] ch;
                ch = 6'($urandom_range(0, 31));
                if ($urandom_range(0, 9) == 0) ch[5] = 1'b1;
                wr(4'(i), mk($urandom_range(0, 7) != 0, $urandom_range(0, 5) == 0,
                              8'($urandom), ch));
            end
            wr(4'b1000, 16'($urandom_range(0, 7)));
            wr(4'b1001, 16'($urandom_range(0, 7)));
            set_en(1);
            for (int s = 0; s < 12; s++)
                send_slot($urandom_range(0, 7) == 0, 8'($urandom), 0, "R3 R4 R5 R6 R7 random");
        end

        done = 1'b1;
        report();
    end

endmodule